// File: doc/BRIEF.md
# Store-Multiple Write Burst Splitter

This block takes one store-multiple request, a run of 1 to 8 consecutive 32-bit words, and turns it into AXI write-address and write-data traffic on a 64-bit write bus. It is meant for stores that go straight to memory, such as noncacheable or write-through stores. A request carries a word-aligned start byte address, a word count and up to eight data words. The block chooses the beat size, burst length, strobes and lane placement for each burst.

A run that stays inside one 32-byte line becomes a single incrementing burst. A run that crosses the line end is cut in two. The first burst carries the words up to the end of the line. The second carries the rest and starts at the base of the next line. The two bursts go out in order on both channels. A new request is accepted only when all address and data beats of the previous one have been handed over.

Top module: `stm_burst_split`

## Requirements
- R1: A run whose words all lie in one 32-byte line produces exactly one AW transfer, and its address equals the request start address.
- R2: A burst whose start address has bit 2 clear and whose word count is even uses 64-bit beats (size code 3). It has count/2 beats, each with strobe 8'hFF and data {higher word, lower word}.
- R3: Any other burst uses 32-bit beats (size code 2) with one word per beat. A beat whose address bit 2 is 0 has strobe 8'h0F and its word in data[31:0]. A beat whose bit 2 is 1 has strobe 8'hF0 and its word in data[63:32]. The unused lane is zero.
- R4: A run that crosses the line end is split. The first burst covers start word to word 7 of the line. The second burst starts at line base + 32 and carries the remaining words.
- R5: The second AW transfer of a split is presented only after the first AW handshake has completed.
- R6: W beats follow burst order and word order. w_last is high exactly on the final beat of each burst, and no beat goes out beyond the request.
- R7: aw_burst is always INCR (2'b01), and aw_len equals the burst's beat count minus one.
- R8: req_ready is high only while no AW or W transfer of an earlier request is outstanding, and a request is taken on req_valid && req_ready. While a valid output waits for ready, its payload stays unchanged.
- R9: A one-word burst, including a one-word piece of a split, is a single 32-bit beat at its own address with aw_len 0.
- R10: During and right after reset, aw_valid and w_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store-multiple request present |
| req_ready | output | 1 | Block idle, request may be taken |
| req_addr | input | 32 | Word-aligned start byte address |
| req_count | input | 4 | Number of words, 1 to 8 |
| req_data | input | 256 | Word i in bits [32*i+31:32*i] |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Burst start address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | Beat size code (2 or 3) |
| aw_burst | output | 2 | Burst type, always INCR |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | 64 | Beat data |
| w_strb | output | 8 | Byte strobes |
| w_last | output | 1 | Final beat of the current burst |

## Verification
The assertions assume that a request is word aligned and has a count from 1 to 8. They also assume that the downstream ready inputs may toggle freely but the request inputs are only sampled on the accept cycle. The bench covers every start word within a line against every legal count, 64 requests in all. Each request uses a fresh line-aligned base and distinct data words. Ready stalls come from a shift register, so hold rules and split ordering are exercised while the stimulus never breaks these assumptions.

// File: rtl/stm_split_pkg.sv
package stm_split_pkg;

   typedef enum logic [1:0] {
      BURST_FIXED = 2'b00,
      BURST_INCR  = 2'b01,
      BURST_WRAP  = 2'b10
   } burst_e;

   // double-width beats only for an even count starting on a beat boundary
   function automatic logic beat_is_wide(input logic half_sel, input logic cnt_lsb);
      return !half_sel && !cnt_lsb;
   endfunction

endpackage

// File: rtl/stm_plan.sv
module stm_plan #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LINE_WORDS = 8,
   localparam int unsigned CNT_W     = $clog2(LINE_WORDS + 1),
   localparam int unsigned IDX_W     = $clog2(LINE_WORDS),
   localparam int unsigned OFF_LSB   = $clog2(WORD_BYTES),
   localparam int unsigned LINE_LSB  = $clog2(WORD_BYTES * LINE_WORDS)
) (
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] a0,
   output logic [ADDR_W-1:0] a1,
   output logic [CNT_W-1:0]  c0,
   output logic [CNT_W-1:0]  c1,
   output logic              two
);
   localparam int unsigned LINE_BYTES = WORD_BYTES * LINE_WORDS;

   logic [IDX_W-1:0] first_word;
   logic [CNT_W-1:0] room;

   assign first_word = start_addr[LINE_LSB-1:OFF_LSB];
   assign room       = CNT_W'(LINE_WORDS) - CNT_W'(first_word);
   assign two        = count > room;
   assign c0         = two ? room : count;
   assign c1         = two ? CNT_W'(count - room) : '0;
   assign a0         = start_addr;
   assign a1         = {start_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}} + ADDR_W'(LINE_BYTES);

endmodule

// File: rtl/stm_aw_ctrl.sv
module stm_aw_ctrl
   import stm_split_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned WORD_BYTES = 4,
   parameter int unsigned LINE_WORDS = 8,
   localparam int unsigned CNT_W     = $clog2(LINE_WORDS + 1),
   localparam int unsigned OFF_LSB   = $clog2(WORD_BYTES),
   localparam int unsigned LINE_LSB  = $clog2(WORD_BYTES * LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] a0,
   input  logic [ADDR_W-1:0] a1,
   input  logic [CNT_W-1:0]  c0,
   input  logic [CNT_W-1:0]  c1,
   input  logic              two,
   output logic              aw_valid,
   input  logic              aw_ready,
   output logic [ADDR_W-1:0] aw_addr,
   output logic [7:0]        aw_len,
   output logic [2:0]        aw_size,
   output logic [1:0]        aw_burst,
   output logic              busy
);
   logic             pend_q, idx_q, hs, wide;
   logic [CNT_W-1:0] cur_cnt, beats;

   assign aw_addr  = idx_q ? a1 : a0;
   assign cur_cnt  = idx_q ? c1 : c0;
   assign wide     = beat_is_wide(aw_addr[OFF_LSB], cur_cnt[0]);
   assign beats    = wide ? (cur_cnt >> 1) : cur_cnt;
   assign aw_len   = 8'(beats - 1'b1);
   assign aw_size  = wide ? 3'(OFF_LSB + 1) : 3'(OFF_LSB);
   assign aw_burst = BURST_INCR;
   assign aw_valid = pend_q;
   assign busy     = pend_q;
   assign hs       = pend_q && aw_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         idx_q  <= 1'b0;
      end else if (start) begin
         pend_q <= 1'b1;
         idx_q  <= 1'b0;
      end else if (hs) begin
         if (idx_q || !two) pend_q <= 1'b0;
         else               idx_q  <= 1'b1;
      end
   end

   p_aw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_size));
   p_second_after_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(idx_q) |-> $past(hs));
   p_second_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
      aw_valid && idx_q |-> aw_addr[LINE_LSB-1:0] == '0);
   p_wide_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      aw_valid && aw_size == 3'(OFF_LSB + 1) |-> !aw_addr[OFF_LSB]);

endmodule

// File: rtl/stm_w_ctrl.sv
module stm_w_ctrl
   import stm_split_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned LINE_WORDS     = 8,
   parameter bit          ZERO_IDLE_LANE = 1'b1,
   localparam int unsigned WORD_BYTES    = WORD_W / 8,
   localparam int unsigned BEAT_BYTES    = 2 * WORD_BYTES,
   localparam int unsigned CNT_W         = $clog2(LINE_WORDS + 1),
   localparam int unsigned IDX_W         = $clog2(LINE_WORDS),
   localparam int unsigned OFF_LSB       = $clog2(WORD_BYTES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [ADDR_W-1:0]            a0,
   input  logic [ADDR_W-1:0]            a1,
   input  logic [CNT_W-1:0]             c0,
   input  logic [CNT_W-1:0]             c1,
   input  logic                         two,
   input  logic [LINE_WORDS*WORD_W-1:0] words,
   output logic                         w_valid,
   input  logic                         w_ready,
   output logic [2*WORD_W-1:0]          w_data,
   output logic [BEAT_BYTES-1:0]        w_strb,
   output logic                         w_last,
   output logic                         busy
);
   localparam logic [BEAT_BYTES-1:0] STRB_LO  = {{WORD_BYTES{1'b0}}, {WORD_BYTES{1'b1}}};
   localparam logic [BEAT_BYTES-1:0] STRB_HI  = {{WORD_BYTES{1'b1}}, {WORD_BYTES{1'b0}}};
   localparam logic [BEAT_BYTES-1:0] STRB_ALL = '1;

   logic [WORD_W-1:0] wrd [LINE_WORDS];
   logic [WORD_W-1:0] lo_word, hi_word, fill;
   logic              pend_q, idx_q, hs, wide, lane;
   logic [CNT_W-1:0]  beat_q, ptr_q, cur_cnt, beats;
   logic [ADDR_W-1:0] cur_addr;

   for (genvar g = 0; g < LINE_WORDS; g++) begin : g_unpack
      assign wrd[g] = words[g*WORD_W +: WORD_W];
   end

   assign cur_addr = idx_q ? a1 : a0;
   assign cur_cnt  = idx_q ? c1 : c0;
   assign wide     = beat_is_wide(cur_addr[OFF_LSB], cur_cnt[0]);
   assign beats    = wide ? (cur_cnt >> 1) : cur_cnt;
   assign lane     = cur_addr[OFF_LSB] ^ beat_q[0];
   assign lo_word  = wrd[ptr_q[IDX_W-1:0]];
   assign hi_word  = wrd[IDX_W'(ptr_q + 1'b1)];

   if (ZERO_IDLE_LANE) begin : g_zero_lane
      assign fill = '0;
   end else begin : g_copy_lane
      assign fill = lo_word;
   end

   always_comb begin
      if (wide) begin
         w_data = {hi_word, lo_word};
         w_strb = STRB_ALL;
      end else if (lane) begin
         w_data = {lo_word, fill};
         w_strb = STRB_HI;
      end else begin
         w_data = {fill, lo_word};
         w_strb = STRB_LO;
      end
   end

   assign w_last  = beat_q == CNT_W'(beats - 1'b1);
   assign w_valid = pend_q;
   assign busy    = pend_q;
   assign hs      = pend_q && w_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         idx_q  <= 1'b0;
         beat_q <= '0;
         ptr_q  <= '0;
      end else if (start) begin
         pend_q <= 1'b1;
         idx_q  <= 1'b0;
         beat_q <= '0;
         ptr_q  <= '0;
      end else if (hs) begin
         ptr_q <= ptr_q + (wide ? CNT_W'(2) : CNT_W'(1));
         if (w_last) begin
            beat_q <= '0;
            if (idx_q || !two) pend_q <= 1'b0;
            else               idx_q  <= 1'b1;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   p_w_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_strb) && $stable(w_last));
   p_strb_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid |-> (w_strb == STRB_LO || w_strb == STRB_HI || w_strb == STRB_ALL));
   p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      w_valid |-> ptr_q < CNT_W'(c0 + c1));
   p_next_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs && w_last && !idx_q && two |=> w_valid && idx_q && beat_q == '0);

endmodule

// File: rtl/stm_burst_split.sv
module stm_burst_split #(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned WORD_W         = 32,
   parameter int unsigned LINE_WORDS     = 8,
   parameter bit          ZERO_IDLE_LANE = 1'b1,
   localparam int unsigned WORD_BYTES    = WORD_W / 8,
   localparam int unsigned BEAT_BYTES    = 2 * WORD_BYTES,
   localparam int unsigned CNT_W         = $clog2(LINE_WORDS + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [ADDR_W-1:0]            req_addr,
   input  logic [CNT_W-1:0]             req_count,
   input  logic [LINE_WORDS*WORD_W-1:0] req_data,
   output logic                         aw_valid,
   input  logic                         aw_ready,
   output logic [ADDR_W-1:0]            aw_addr,
   output logic [7:0]                   aw_len,
   output logic [2:0]                   aw_size,
   output logic [1:0]                   aw_burst,
   output logic                         w_valid,
   input  logic                         w_ready,
   output logic [2*WORD_W-1:0]          w_data,
   output logic [BEAT_BYTES-1:0]        w_strb,
   output logic                         w_last
);
   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("stm_burst_split: WORD_W must be a byte multiple of at least 16");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_line
      $error("stm_burst_split: LINE_WORDS must be a power of two of at least 2");
   end
   if (LINE_WORDS * WORD_BYTES * 8 > 4096) begin : g_bad_len
      $error("stm_burst_split: line too long for an 8-bit burst length");
   end

   logic [ADDR_W-1:0]            pa0, pa1, a0_q, a1_q;
   logic [CNT_W-1:0]             pc0, pc1, c0_q, c1_q;
   logic                         ptwo, two_q, accept, aw_busy, w_busy;
   logic [LINE_WORDS*WORD_W-1:0] words_q;

   stm_plan #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_WORDS(LINE_WORDS)) i_plan (
      .start_addr(req_addr), .count(req_count),
      .a0(pa0), .a1(pa1), .c0(pc0), .c1(pc1), .two(ptwo)
   );

   assign req_ready = !(aw_busy || w_busy);
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a0_q    <= '0;
         a1_q    <= '0;
         c0_q    <= '0;
         c1_q    <= '0;
         two_q   <= 1'b0;
         words_q <= '0;
      end else if (accept) begin
         a0_q    <= pa0;
         a1_q    <= pa1;
         c0_q    <= pc0;
         c1_q    <= pc1;
         two_q   <= ptwo;
         words_q <= req_data;
      end
   end

   stm_aw_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .LINE_WORDS(LINE_WORDS)) i_aw (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .a0(a0_q), .a1(a1_q), .c0(c0_q), .c1(c1_q), .two(two_q),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst), .busy(aw_busy)
   );

   stm_w_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS),
                .ZERO_IDLE_LANE(ZERO_IDLE_LANE)) i_w (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .a0(a0_q), .a1(a1_q), .c0(c0_q), .c1(c1_q), .two(two_q), .words(words_q),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
      .w_last(w_last), .busy(w_busy)
   );

   p_req_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> req_count != '0 && req_count <= CNT_W'(LINE_WORDS));
   p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> aw_valid && w_valid && !req_ready);

endmodule

// File: tb/test_stm_burst_split.sv
`timescale 1ns/1ps
module test_stm_burst_split;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [31:0]  req_addr = '0;
   logic [3:0]   req_count = '0;
   logic [255:0] req_data = '0;
   logic         aw_valid, aw_ready = 1'b0;
   logic [31:0]  aw_addr;
   logic [7:0]   aw_len;
   logic [2:0]   aw_size;
   logic [1:0]   aw_burst;
   logic         w_valid, w_ready = 1'b0;
   logic [63:0]  w_data;
   logic [7:0]   w_strb;
   logic         w_last;

   int total = 0;
   int bad = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   stm_burst_split i_stm_burst_split (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_count(req_count), .req_data(req_data),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
      .aw_size(aw_size), .aw_burst(aw_burst),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run(input int w, input int cnt, input logic [31:0] base);
      logic [31:0] dd [8];
      logic [31:0] e_addr [2];
      logic [7:0]  e_len [2];
      logic [2:0]  e_size [2];
      logic [63:0] e_data [16];
      logic [7:0]  e_strb [16];
      logic        e_last [16];
      int n_aw, n_w, k, ia, iw, cyc;
      logic [31:0] pa [2];
      int pc [2];
      logic stall_aw;
      logic [31:0] held_addr;
      int room;
      for (int i = 0; i < 8; i++) dd[i] = {8'(w), 8'(cnt), 8'(i), 8'h5A};
      room = 8 - w;
      pa[0] = base + 32'(w * 4);
      pa[1] = base + 32'd32;
      pc[0] = (cnt < room) ? cnt : room;
      pc[1] = cnt - pc[0];
      n_aw = (pc[1] > 0) ? 2 : 1;
      n_w = 0;
      k = 0;
      for (int p = 0; p < n_aw; p++) begin
         logic wide;
         int beats;
         wide = !pa[p][2] && (pc[p] % 2 == 0);
         beats = wide ? pc[p] / 2 : pc[p];
         e_addr[p] = pa[p];
         e_len[p]  = 8'(beats - 1);
         e_size[p] = wide ? 3'd3 : 3'd2;
         for (int b = 0; b < beats; b++) begin
            if (wide) begin
               e_data[n_w] = {dd[k + 1], dd[k]};
               e_strb[n_w] = 8'hFF;
               k += 2;
            end else begin
               if ((int'(pa[p][2]) + b) % 2 == 1) begin
                  e_data[n_w] = {dd[k], 32'h0};
                  e_strb[n_w] = 8'hF0;
               end else begin
                  e_data[n_w] = {32'h0, dd[k]};
                  e_strb[n_w] = 8'h0F;
               end
               k += 1;
            end
            e_last[n_w] = (b == beats - 1);
            n_w++;
         end
      end

      @(negedge clk);
      req_addr  = base + 32'(w * 4);
      req_count = 4'(cnt);
      for (int i = 0; i < 8; i++) req_data[i*32 +: 32] = dd[i];
      req_valid = 1'b1;
      chk("R8 ready while idle", 64'(req_ready), 64'd1);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R8 busy after accept", 64'(req_ready), 64'd0);

      ia = 0; iw = 0; cyc = 0; stall_aw = 1'b0; held_addr = '0;
      while ((ia < n_aw || iw < n_w) && cyc < 400) begin
         if (stall_aw) begin
            chk("R8 address held under stall", {aw_valid, aw_addr}, {1'b1, held_addr});
         end
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         aw_ready = lfsr[0] | lfsr[3];
         w_ready  = lfsr[1] | lfsr[6];
         stall_aw = aw_valid && !aw_ready;
         held_addr = aw_addr;
         if (aw_valid && aw_ready) begin
            if (ia >= n_aw) begin
               chk("R1 extra address transfer", 64'(ia), 64'(n_aw));
            end else begin
               if (n_aw == 1)      chk("R1 single burst address", 64'(aw_addr), 64'(e_addr[ia]));
               else if (ia == 0)   chk("R4 first piece address", 64'(aw_addr), 64'(e_addr[ia]));
               else                chk("R5 R4 second piece after first", 64'(aw_addr), 64'(e_addr[ia]));
               if (e_size[ia] == 3'd3) chk("R2 wide size", 64'(aw_size), 64'(e_size[ia]));
               else                    chk("R3 narrow size", 64'(aw_size), 64'(e_size[ia]));
               if (e_len[ia] == 8'd0 && e_size[ia] == 3'd2)
                  chk("R9 single word length", 64'(aw_len), 64'(e_len[ia]));
               else
                  chk("R7 burst length", 64'(aw_len), 64'(e_len[ia]));
               chk("R7 burst type INCR", 64'(aw_burst), 64'd1);
               ia++;
            end
         end
         if (w_valid && w_ready) begin
            if (iw >= n_w) begin
               chk("R6 extra data beat", 64'(iw), 64'(n_w));
            end else begin
               if (e_strb[iw] == 8'hFF) begin
                  chk("R2 wide beat data", w_data, e_data[iw]);
                  chk("R2 wide beat strobe", 64'(w_strb), 64'(e_strb[iw]));
               end else begin
                  chk("R3 narrow beat data", w_data, e_data[iw]);
                  chk("R3 narrow beat strobe", 64'(w_strb), 64'(e_strb[iw]));
               end
               chk("R6 last flag", 64'(w_last), 64'(e_last[iw]));
               iw++;
            end
         end
         @(negedge clk);
         cyc++;
      end
      aw_ready = 1'b0;
      w_ready  = 1'b0;
      if (cyc >= 400) begin
         total++;
         bad++;
         $display("FAIL R6 request w=%0d cnt=%0d hung act=%0d/%0d exp=%0d/%0d", w, cnt, ia, iw, n_aw, n_w);
      end
      chk("R6 idle after request", {61'd0, req_ready, aw_valid, w_valid}, 64'b100);
   endtask

   initial begin
      #(64'd200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 outputs quiet in reset", {61'd0, req_ready, aw_valid, w_valid}, 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 outputs quiet after reset", {61'd0, req_ready, aw_valid, w_valid}, 64'b100);
      for (int w = 0; w < 8; w++) begin
         for (int c = 1; c <= 8; c++) begin
            run(w, c, 32'h0004_0000 + 32'((w * 8 + c) * 64));
         end
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule